// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the pin timing of an 8-bit controller's external memory bus. It runs on the oscillator clock. A machine cycle is twelve oscillator ticks, made of six states of two ticks each. Each half of a machine cycle (six ticks) is one transfer slot. A slot can be idle, a code fetch, a data-address phase, a data read or a data write. The low address byte and the data share one multiplexed 8-bit bus. The high address byte has its own 8-bit output. An address latch enable pulse lets external logic hold the low byte. Program-store, read and write strobes are active low.

The core presents a request on `req_op`, `req_pc`, `req_daddr` and `req_wdata`. The block takes it on the clock edge that ends a tick in which `req_take` is high. The op codes are: 0 none, 1 fetch, 2 data read, 3 data write. A fetch lasts one machine cycle and reads code bytes at `pc` and `pc+1`. A data access lasts two machine cycles. The first half of the first cycle fetches at `pc`. The second half latches the data address. The first half of the second cycle carries the read or write strobe, and the second half fetches at `pc+1`. The level of `ea_pin` while reset is held chooses where code comes from. If it is low, code comes from external memory and fetch slots drive the bus. If it is high, code comes from internal memory and fetch slots stay silent on the bus.

Top module: `ema_strobe_seq`

## Requirements
- R1: `ea_pin` is captured on every clock edge while `rst` is high and is ignored afterwards. A captured 1 turns every fetch slot into an idle slot: `psen_n` stays 1, the bus is not driven and `addr_hi` reads 0. A captured 0 enables external fetches.
- R2: While `rst` is high, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0, `req_take`=0, `code_valid`=0 and `rd_valid`=0.
- R3: Ticks are numbered 0 to 11 from the edge that takes a request. `ale` is 1 exactly in ticks 1 and 7 of every machine cycle, one tick wide, unless R4 or R5 applies.
- R4: In ticks 0 to 5 of the second machine cycle of a data access, `ale` stays 0.
- R5: While `quiet_ale` is 1, `ale` stays 0.
- R6: In an external fetch slot, `ad_oe`=1 and `ad_out` carries the low address byte in slot ticks 0 and 1, and `psen_n`=0 in slot ticks 3 to 5. The address is `pc` in the first half and `pc+1` (modulo 2^16) in the second half. `ad_out` reads 0 whenever `ad_oe` is 0.
- R7: `ad_in` is sampled at the edge that ends the last `psen_n`-low tick. The next tick shows `code_valid`=1 with that byte on `code_byte`. `code_valid` is 0 otherwise.
- R8: A data access spans two machine cycles and brings exactly two `psen_n` falling edges in external mode: one in the first half of the first cycle and one in the second half of the second cycle.
- R9: For a read, `rd_n`=0 in ticks 0 to 5 of the second cycle, with the bus released. `ad_in` sampled at the edge ending tick 5 appears on `rd_byte`, with `rd_valid`=1, in tick 6.
- R10: For a write, `wr_n`=0 in ticks 0 to 5 of the second cycle, with `ad_oe`=1 and `ad_out`=`req_wdata` held for the whole strobe.
- R11: `ad_oe` is 0 in every tick where `psen_n` or `rd_n` is 0. At most one of the three strobes is low at a time.
- R12: `req_take` is 1 only in tick 11, and not in tick 11 of the first cycle of a data access. Request inputs are ignored in every other tick.
- R13: `addr_hi` carries the high byte of the fetch address through a fetch slot. It carries the high byte of the data address from tick 6 of the first cycle through tick 5 of the second cycle, and 0 in idle slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one tick per period |
| rst | input | 1 | Synchronous reset, active high |
| ea_pin | input | 1 | Code-source select, captured during reset (1 internal, 0 external) |
| quiet_ale | input | 1 | Noise-reduction control, 1 holds `ale` low |
| req_op | input | 2 | Request code: 0 none, 1 fetch, 2 read, 3 write |
| req_pc | input | 16 | Program address for fetch slots |
| req_daddr | input | 16 | Data address for reads and writes |
| req_wdata | input | 8 | Write byte |
| req_take | output | 1 | High in the tick whose closing edge takes a request |
| ad_in | input | 8 | Multiplexed bus, input side |
| ad_out | output | 8 | Multiplexed bus, output side |
| ad_oe | output | 1 | Output enable of the multiplexed bus |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| code_byte | output | 8 | Last fetched code byte |
| code_valid | output | 1 | One-tick pulse, `code_byte` is new |
| rd_byte | output | 8 | Last read data byte |
| rd_valid | output | 1 | One-tick pulse, `rd_byte` is new |

## Verification
The hardest case to reach is the closing edge of the first cycle of a data access. The request inputs are live there, but the block must ignore them and carry on with the latched access. The bench drives random requests on every tick that is not a take tick. Every value that reaches the pins should therefore come from the latched request. Directed accesses cover a fetch at the top of the address space, where `pc+1` wraps. Random ops are mixed with noise reduction and with both code sources. Each of those modes needs its own reset, because `ea_pin` is only read while reset is held.

// File: rtl/ema_pkg.sv
package ema_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_FETCH = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MC_IDLE   = 2'd0,
    MC_FETCH  = 2'd1,
    MC_DATA_A = 2'd2,
    MC_DATA_B = 2'd3
  } mc_e;

  typedef enum logic [2:0] {
    SL_IDLE  = 3'd0,
    SL_FETCH = 3'd1,
    SL_DADDR = 3'd2,
    SL_READ  = 3'd3,
    SL_WRITE = 3'd4
  } slot_e;

  // Slot carried by one half of a machine cycle.
  function automatic slot_e slot_pick(mc_e mc, logic second_half, logic is_write,
                                      logic ext_code);
    slot_e s;
    case (mc)
      MC_FETCH:  s = SL_FETCH;
      MC_DATA_A: s = second_half ? SL_DADDR : SL_FETCH;
      MC_DATA_B: s = second_half ? SL_FETCH : (is_write ? SL_WRITE : SL_READ);
      default:   s = SL_IDLE;
    endcase
    if (s == SL_FETCH && !ext_code) s = SL_IDLE;
    return s;
  endfunction

  // Slot tick windows, st = ticks per state, q = tick inside the slot.
  function automatic logic ale_window(int q, int st);
    return q == st - 1;                       // second half of first state
  endfunction

  function automatic logic addr_window(int q, int st);
    return q < st;                            // whole first state
  endfunction

  function automatic logic psen_window(int q, int st);
    return (q >= 2 * st - 1) && (q < 3 * st); // second half of state 2 to end of state 3
  endfunction

  function automatic logic slot_last(int q, int st);
    return q == 3 * st - 1;
  endfunction

endpackage

// File: rtl/ema_timebase.sv
module ema_timebase
  import ema_pkg::*;
#(
  parameter int STATE_TICKS = 2,
  parameter int TW          = $clog2(6 * STATE_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] slot_tick,
  output logic          second_half,
  output logic          mc_end
);

  localparam int HALF_TICKS = 3 * STATE_TICKS;
  localparam int MC_TICKS   = 2 * HALF_TICKS;
  localparam logic [TW-1:0] LAST = TW'(MC_TICKS - 1);
  localparam logic [TW-1:0] HALF = TW'(HALF_TICKS);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst)                 tick_q <= LAST;
    else if (tick_q == LAST) tick_q <= '0;
    else                     tick_q <= tick_q + 1'b1;
  end

  assign second_half = (tick_q >= HALF);
  assign slot_tick   = second_half ? (tick_q - HALF) : tick_q;
  assign mc_end      = (tick_q == LAST);

  // R3: machine cycle wraps to tick 0 after its last tick
  p_tick_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    mc_end |=> (tick_q == '0));

  // R3: a slot's last tick in the first half leads into the second half
  p_half_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (!second_half && slot_tick == HALF - 1'b1) |=> second_half);

endmodule

// File: rtl/ema_sequencer.sv
module ema_sequencer
  import ema_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ea_pin,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_daddr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mc_end,
  input  logic              second_half,
  output logic              req_take,
  output slot_e             slot,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [DATA_W-1:0] slot_wdata,
  output logic              ext_code
);

  mc_e               mc_q;
  logic [ADDR_W-1:0] pc_q, da_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_q;
  logic              ea_q;

  // Code source is captured while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (rst) ea_q <= ea_pin;
  end
  assign ext_code = ~ea_q;

  assign req_take = mc_end && (mc_q != MC_DATA_A) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= MC_IDLE;
      pc_q <= '0;
      da_q <= '0;
      wd_q <= '0;
      wr_q <= 1'b0;
    end else if (mc_end) begin
      if (mc_q == MC_DATA_A) begin
        mc_q <= MC_DATA_B;
      end else begin
        case (req_op)
          OP_FETCH:           mc_q <= MC_FETCH;
          OP_READ, OP_WRITE:  mc_q <= MC_DATA_A;
          default:            mc_q <= MC_IDLE;
        endcase
        pc_q <= req_pc;
        da_q <= req_daddr;
        wd_q <= req_wdata;
        wr_q <= (req_op == OP_WRITE);
      end
    end
  end

  assign slot       = slot_pick(mc_q, second_half, wr_q, ext_code);
  assign slot_wdata = wd_q;

  always_comb begin
    case (slot)
      SL_FETCH:                    slot_addr = pc_q + ADDR_W'(second_half);
      SL_DADDR, SL_READ, SL_WRITE: slot_addr = da_q;
      default:                     slot_addr = '0;
    endcase
  end

  // R1: code source does not move once reset is released
  p_ea_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(ext_code));

  // R8: the first data cycle is always followed by the second
  p_b_after_a_r8: assert property (@(posedge clk) disable iff (rst)
    (mc_end && mc_q == MC_DATA_A) |=> (mc_q == MC_DATA_B));

  // R8: the second data cycle never repeats
  p_b_single_r8: assert property (@(posedge clk) disable iff (rst)
    (mc_end && mc_q == MC_DATA_B) |=> (mc_q != MC_DATA_B));

endmodule

// File: rtl/ema_pin_driver.sv
module ema_pin_driver
  import ema_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STATE_TICKS = 2,
  parameter int TW          = $clog2(6 * STATE_TICKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     quiet_ale,
  input  slot_e                    slot,
  input  logic [ADDR_W-1:0]        slot_addr,
  input  logic [DATA_W-1:0]        slot_wdata,
  input  logic [TW-1:0]            slot_tick,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        code_byte,
  output logic                     code_valid,
  output logic [DATA_W-1:0]        rd_byte,
  output logic                     rd_valid
);

  logic ale_due, addr_due, psen_due, end_due;
  logic is_strobe, drives_addr;

  always_comb begin
    ale_due  = ale_window(int'(slot_tick), STATE_TICKS);
    addr_due = addr_window(int'(slot_tick), STATE_TICKS);
    psen_due = psen_window(int'(slot_tick), STATE_TICKS);
    end_due  = slot_last(int'(slot_tick), STATE_TICKS);
  end

  assign is_strobe   = (slot == SL_READ) || (slot == SL_WRITE);
  assign drives_addr = ((slot == SL_FETCH) || (slot == SL_DADDR)) && addr_due;

  always_comb begin
    ad_oe   = 1'b0;
    ad_out  = '0;
    ale     = 1'b0;
    psen_n  = 1'b1;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    addr_hi = '0;
    if (!rst) begin
      ale    = ale_due && !is_strobe && !quiet_ale;
      psen_n = !((slot == SL_FETCH) && psen_due);
      rd_n   = (slot != SL_READ);
      wr_n   = (slot != SL_WRITE);
      if (drives_addr) begin
        ad_oe  = 1'b1;
        ad_out = slot_addr[DATA_W-1:0];
      end else if (slot == SL_WRITE) begin
        ad_oe  = 1'b1;
        ad_out = slot_wdata;
      end
      if (slot != SL_IDLE) addr_hi = slot_addr[ADDR_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_valid <= 1'b0;
      rd_valid   <= 1'b0;
      code_byte  <= '0;
      rd_byte    <= '0;
    end else begin
      code_valid <= (slot == SL_FETCH) && end_due;
      rd_valid   <= (slot == SL_READ) && end_due;
      if ((slot == SL_FETCH) && end_due) code_byte <= ad_in;
      if ((slot == SL_READ) && end_due)  rd_byte   <= ad_in;
    end
  end

  // R11: bus released while a read-type strobe is low
  p_bus_free_r11: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe);

  // R11: never two strobes at once
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!psen_n, !rd_n, !wr_n}));

  // R3: address latch pulse is one tick wide
  p_ale_single_r3: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R5: quiet mode silences the latch strobe
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    quiet_ale |-> !ale);

  // R10: write data stays put for the whole strobe
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !$past(wr_n)) |-> ($stable(ad_out) && ad_oe));

  // R7: capture pulses are isolated
  p_code_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> !code_valid);

endmodule

// File: rtl/ema_strobe_seq.sv
module ema_strobe_seq
  import ema_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STATE_TICKS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ea_pin,
  input  logic                     quiet_ale,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_pc,
  input  logic [ADDR_W-1:0]        req_daddr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_take,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        code_byte,
  output logic                     code_valid,
  output logic [DATA_W-1:0]        rd_byte,
  output logic                     rd_valid
);

  localparam int TW = $clog2(6 * STATE_TICKS);

  logic [TW-1:0]     slot_tick;
  logic              second_half;
  logic              mc_end;
  slot_e             slot;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_wdata;
  logic              ext_code;

  ema_timebase #(
    .STATE_TICKS(STATE_TICKS),
    .TW         (TW)
  ) u_timebase (
    .clk        (clk),
    .rst        (rst),
    .slot_tick  (slot_tick),
    .second_half(second_half),
    .mc_end     (mc_end)
  );

  ema_sequencer #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_sequencer (
    .clk        (clk),
    .rst        (rst),
    .ea_pin     (ea_pin),
    .req_op     (req_op),
    .req_pc     (req_pc),
    .req_daddr  (req_daddr),
    .req_wdata  (req_wdata),
    .mc_end     (mc_end),
    .second_half(second_half),
    .req_take   (req_take),
    .slot       (slot),
    .slot_addr  (slot_addr),
    .slot_wdata (slot_wdata),
    .ext_code   (ext_code)
  );

  ema_pin_driver #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STATE_TICKS(STATE_TICKS),
    .TW         (TW)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .quiet_ale (quiet_ale),
    .slot      (slot),
    .slot_addr (slot_addr),
    .slot_wdata(slot_wdata),
    .slot_tick (slot_tick),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .code_byte (code_byte),
    .code_valid(code_valid),
    .rd_byte   (rd_byte),
    .rd_valid  (rd_valid)
  );

  // R1: internal code source never raises the program strobe
  p_psen_internal_r1: assert property (@(posedge clk) disable iff (rst)
    !ext_code |-> psen_n);

  // R12: a take is always followed by tick 0 of a new cycle, no back-to-back takes
  p_take_spacing_r12: assert property (@(posedge clk) disable iff (rst)
    req_take |=> !req_take);

endmodule

// File: tb/ema_strobe_seq_tb.sv
module ema_strobe_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ea_pin = 1'b0;
  logic        quiet_ale = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_pc = 16'h0, req_daddr = 16'h0;
  logic [7:0]  req_wdata = 8'h0, ad_in = 8'h0;
  logic        req_take, ad_oe, ale, psen_n, rd_n, wr_n, code_valid, rd_valid;
  logic [7:0]  ad_out, addr_hi, code_byte, rd_byte;

  ema_strobe_seq u_dut (
    .clk(clk), .rst(rst), .ea_pin(ea_pin), .quiet_ale(quiet_ale),
    .req_op(req_op), .req_pc(req_pc), .req_daddr(req_daddr), .req_wdata(req_wdata),
    .req_take(req_take), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .code_byte(code_byte), .code_valid(code_valid), .rd_byte(rd_byte), .rd_valid(rd_valid)
  );

  always #4 clk = ~clk;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  bit   ext_mode = 1;
  bit   prev_code_cap = 0, prev_data_cap = 0;
  logic [7:0] prev_ad = 8'h0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Slot code: 0 idle, 1 fetch, 2 data address, 3 read, 4 write.
  function automatic int slot_of(int kind, int m, int t, bit ext);
    int h, s;
    h = t / 6;
    s = 0;
    if (kind == 1) s = 1;
    else if (kind >= 2) begin
      if (m == 0) s = (h == 0) ? 1 : 2;
      else        s = (h == 1) ? 1 : ((kind == 3) ? 4 : 3);
    end
    if (s == 1 && !ext) s = 0;
    return s;
  endfunction

  // {take, ale, psen_n, rd_n, wr_n, oe, ad_out[7:0], addr_hi[7:0]}
  function automatic logic [21:0] expect_pins(int kind, int m, int t, logic [15:0] pc,
                                              logic [15:0] da, logic [7:0] wd, bit ext, bit qt);
    int s, q, h;
    logic [15:0] a;
    logic tk, al, ps, rd, wr, oe;
    logic [7:0] ad, hi;
    s = slot_of(kind, m, t, ext);
    q = t % 6;
    h = t / 6;
    a = 16'h0;
    if (s == 1) a = pc + 16'(h);
    else if (s >= 2) a = da;
    tk = (t == 11) && (kind < 2 || m == 1);
    al = !qt && (q == 1) && (s != 3) && (s != 4);
    ps = !(s == 1 && q >= 3);
    rd = (s != 3);
    wr = (s != 4);
    oe = ((s == 1 || s == 2) && q < 2) || (s == 4);
    ad = (s == 4) ? wd : (oe ? a[7:0] : 8'h00);
    hi = (s == 0) ? 8'h00 : a[15:8];
    return {tk, al, ps, rd, wr, oe, ad, hi};
  endfunction

  task automatic run_op(int kind, logic [15:0] pc, logic [15:0] da, logic [7:0] wd, bit qt);
    int ncyc, falls, exp_falls, s;
    logic last_psen;
    logic [21:0] e, a;
    string atag;
    ncyc = (kind >= 2) ? 2 : 1;
    falls = 0;
    check("R12 take point", req_take, 1);
    req_op = kind[1:0]; req_pc = pc; req_daddr = da; req_wdata = wd; quiet_ale = qt;
    last_psen = 1'b1;
    for (int m = 0; m < ncyc; m++) begin
      for (int t = 0; t < 12; t++) begin
        @(negedge clk);
        a = {req_take, ale, psen_n, rd_n, wr_n, ad_oe, ad_out, addr_hi};
        e = expect_pins(kind, m, t, pc, da, wd, ext_mode, qt);
        s = slot_of(kind, m, t, ext_mode);
        if (kind >= 2 && m == 1 && t < 6) atag = "R4 ale";
        else if (qt)                      atag = "R5 ale";
        else                              atag = "R3 ale";
        check("R12 req_take", a[21], e[21]);
        check(atag, a[20], e[20]);
        check(!ext_mode ? "R1 psen_n" : (kind >= 2 ? "R8 psen_n" : "R6 psen_n"), a[19], e[19]);
        check("R9 rd_n", a[18], e[18]);
        check("R10 wr_n", a[17], e[17]);
        check("R11 ad_oe", a[16], e[16]);
        check(s == 4 ? "R10 ad_out" : "R6 ad_out", a[15:8], e[15:8]);
        check("R13 addr_hi", a[7:0], e[7:0]);
        check("R7 code_valid", code_valid, prev_code_cap);
        if (prev_code_cap) check("R7 code_byte", code_byte, prev_ad);
        check("R9 rd_valid", rd_valid, prev_data_cap);
        if (prev_data_cap) check("R9 rd_byte", rd_byte, prev_ad);
        prev_code_cap = (s == 1) && (t % 6 == 5);
        prev_data_cap = (s == 3) && (t % 6 == 5);
        if (last_psen && !psen_n) falls++;
        last_psen = psen_n;
        prev_ad = 8'($urandom);
        ad_in = prev_ad;
        if (!(m == ncyc - 1 && t == 11)) begin
          req_op    = 2'($urandom);
          req_pc    = 16'($urandom);
          req_daddr = 16'($urandom);
          req_wdata = 8'($urandom);
        end
      end
    end
    exp_falls = (ext_mode && kind != 0) ? 2 : 0;
    check("R8 psen pulses per op", falls, exp_falls);
  endtask

  task automatic do_reset(bit ea);
    @(negedge clk);
    rst = 1'b1;
    ea_pin = ea;
    req_op = 2'($urandom);
    repeat (3) @(negedge clk);
    check("R2 ale", ale, 0);
    check("R2 psen_n", psen_n, 1);
    check("R2 rd_n", rd_n, 1);
    check("R2 wr_n", wr_n, 1);
    check("R2 ad_oe", ad_oe, 0);
    check("R2 req_take", req_take, 0);
    check("R2 valids", {code_valid, rd_valid}, 0);
    rst = 1'b0;
    ea_pin = ~ea;            // R1: later changes must not matter
    ext_mode = !ea;
    prev_code_cap = 0;
    prev_data_cap = 0;
    #1;
  endtask

  task automatic random_ops(int n);
    for (int i = 0; i < n; i++)
      run_op(int'($urandom % 4), 16'($urandom), 16'($urandom), 8'($urandom),
             ($urandom % 4) == 0);
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd24681357);
    do_reset(1'b0);
    // external code source, directed corners
    run_op(1, 16'h1234, 16'h0000, 8'h00, 0);
    run_op(1, 16'hFFFF, 16'h0000, 8'h00, 0);   // R6 pc+1 wraps
    run_op(2, 16'h0100, 16'hBEEF, 8'h00, 0);
    run_op(3, 16'h2000, 16'h8001, 8'h5A, 0);
    run_op(0, 16'h0000, 16'h0000, 8'h00, 0);
    run_op(3, 16'h00FF, 16'h7F00, 8'hA5, 1);   // R5 with a data access
    run_op(2, 16'hFFFF, 16'hFFFF, 8'h00, 1);
    random_ops(40);
    // internal code source
    do_reset(1'b1);
    run_op(1, 16'h4321, 16'h0000, 8'h00, 0);   // R1 no external fetch
    run_op(2, 16'h0010, 16'h1234, 8'h00, 0);
    run_op(3, 16'h0020, 16'h5678, 8'h3C, 0);
    random_ops(15);
    do_reset(1'b0);
    random_ops(15);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule